// File: doc/BRIEF.md
# Up/Down Decade Counter with Parallel Load

This block is a synchronous single-digit BCD counter. A direction input selects whether it steps upward through the decimal digits 0 to 9 or downward through 9 to 0. In both directions it wraps around at the end of the decade. A count-enable input gates stepping. A load strobe replaces the held value with a 4-bit word on the next clock edge, and it always wins over counting.

Two outputs support cascading several digits. The first is an end-of-decade flag. It is high whenever the held value is the terminal value for the direction now selected: 9 when rising, 0 when falling. The second is an active-low carry/borrow output. It falls only while counting is enabled and the terminal value is held, so the next digit can use it as its own enable.

A loaded value outside the decade (10 to 15) is kept until the next step. That step always returns the counter to the decade: an upward step gives 0 and a downward step gives 9.

Top module: `bcd_updown_ctr`

## Requirements
- R1: While `rst_n` is low the count is 0, and it stays 0 until the first active step after release.
- R2: With `load` low, `cnt_en` high and `dn_up` = 0 (upward), each rising clock edge moves a count 0..8 to count+1 and moves 9 to 0.
- R3: With `load` low, `cnt_en` high and `dn_up` = 1 (downward), each rising clock edge moves a count 1..9 to count-1 and moves 0 to 9.
- R4: With `load` low and `cnt_en` low, the count does not change at a clock edge, whatever the value of `dn_up`.
- R5: With `load` high, the clock edge stores `load_val`, including 10 to 15, regardless of `cnt_en` and `dn_up`.
- R6: From a held value of 10 to 15, an upward enabled step gives 0.
- R7: From a held value of 10 to 15, a downward enabled step gives 9.
- R8: `at_end` is 1 exactly when (`dn_up` = 0 and count = 9) or (`dn_up` = 1 and count = 0). It is 0 for every value of 10 to 15.
- R9: `ripple_n` is 0 exactly when `cnt_en` = 1 and `at_end` = 1. Otherwise it is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low, clears the count |
| dn_up | input | 1 | Direction: 0 counts upward, 1 counts downward |
| cnt_en | input | 1 | Count enable, active high |
| load | input | 1 | Parallel load strobe, active high, priority over counting |
| load_val | input | 4 | Value stored when `load` is high |
| count | output | 4 | Current BCD digit (may hold 10..15 after a load) |
| at_end | output | 1 | High when the digit is terminal for the current direction |
| ripple_n | output | 1 | Active-low cascade output: low when enabled and terminal |

## Verification
The clocked properties assume that `load`, `cnt_en`, `dn_up` and `load_val` are stable around the rising edge and are never unknown once reset is released. The bench therefore changes every input only on the falling clock edge and always drives defined values, including during reset. The wrap and illegal-value properties read the inputs at the sampling edge. For this reason the stimulus also reverses direction and toggles the enable on the very edge at which the counter sits at 0, at 9 or at an illegal value. Every value from 0 to 15 is loaded and then stepped in both directions, so each recovery path is reached.

// File: rtl/bcd_ctr_pkg.sv
package bcd_ctr_pkg;

  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } dir_e;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_LOAD = 2'd1,
    STEP_UP   = 2'd2,
    STEP_DOWN = 2'd3
  } step_e;

endpackage

// File: rtl/bcd_step_sel.sv
module bcd_step_sel
  import bcd_ctr_pkg::*;
(
  input  logic  load,
  input  logic  cnt_en,
  input  logic  dn_up,
  output step_e step_kind
);

  dir_e dir;
  assign dir = dir_e'(dn_up);

  // load beats enable; enable gates direction
  always_comb begin
    if (load)              step_kind = STEP_LOAD;
    else if (!cnt_en)      step_kind = STEP_HOLD;
    else if (dir == DIR_UP) step_kind = STEP_UP;
    else                   step_kind = STEP_DOWN;
  end

endmodule

// File: rtl/bcd_next.sv
module bcd_next
  import bcd_ctr_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int LAST  = 9
) (
  input  step_e            step_kind,
  input  logic [CNT_W-1:0] cur,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] next_val,
  output logic             illegal_now
);

  localparam logic [CNT_W-1:0] TOP_V  = LAST[CNT_W-1:0];
  localparam logic [CNT_W-1:0] ONE_V  = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [CNT_W-1:0] ZERO_V = '0;

  // upward step: anything at or past the top wraps to zero
  function automatic logic [CNT_W-1:0] step_up(input logic [CNT_W-1:0] v);
    if (v >= TOP_V) return ZERO_V;
    return v + ONE_V;
  endfunction

  // downward step: zero and out-of-range values land on the top
  function automatic logic [CNT_W-1:0] step_down(input logic [CNT_W-1:0] v);
    if (v == ZERO_V || v > TOP_V) return TOP_V;
    return v - ONE_V;
  endfunction

  assign illegal_now = (cur > TOP_V);

  always_comb begin
    case (step_kind)
      STEP_LOAD: next_val = load_val;
      STEP_UP:   next_val = step_up(cur);
      STEP_DOWN: next_val = step_down(cur);
      default:   next_val = cur;
    endcase
  end

endmodule

// File: rtl/bcd_term_detect.sv
module bcd_term_detect
  import bcd_ctr_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int LAST  = 9
) (
  input  logic [CNT_W-1:0] count,
  input  logic             dn_up,
  input  logic             cnt_en,
  output logic             at_end,
  output logic             ripple_n
);

  localparam logic [CNT_W-1:0] TOP_V = LAST[CNT_W-1:0];

  dir_e dir;
  logic hit_top;
  logic hit_bottom;

  assign dir        = dir_e'(dn_up);
  assign hit_top    = (count == TOP_V);
  assign hit_bottom = (count == '0);

  assign at_end   = (dir == DIR_UP) ? hit_top : hit_bottom;
  assign ripple_n = ~(cnt_en & at_end);

endmodule

// File: rtl/bcd_updown_ctr.sv
module bcd_updown_ctr
  import bcd_ctr_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int LAST  = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dn_up,
  input  logic             cnt_en,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count,
  output logic             at_end,
  output logic             ripple_n
);

  localparam logic [CNT_W-1:0] TOP_V = LAST[CNT_W-1:0];

  step_e            step_kind;
  logic [CNT_W-1:0] next_val;
  logic             illegal_now;

  bcd_step_sel u_sel (
    .load      (load),
    .cnt_en    (cnt_en),
    .dn_up     (dn_up),
    .step_kind (step_kind)
  );

  bcd_next #(.CNT_W(CNT_W), .LAST(LAST)) u_next (
    .step_kind   (step_kind),
    .cur         (count),
    .load_val    (load_val),
    .next_val    (next_val),
    .illegal_now (illegal_now)
  );

  bcd_term_detect #(.CNT_W(CNT_W), .LAST(LAST)) u_term (
    .count    (count),
    .dn_up    (dn_up),
    .cnt_en   (cnt_en),
    .at_end   (at_end),
    .ripple_n (ripple_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= next_val;
  end

  // ---------------- assertions ----------------
  assert_up_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_en && !dn_up && count == TOP_V) |=> (count == '0));

  assert_down_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_en && dn_up && count == '0) |=> (count == TOP_V));

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !cnt_en) |=> $stable(count));

  assert_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (count == $past(load_val)));

  assert_illegal_up_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_en && !dn_up && illegal_now) |=> (count == '0));

  assert_illegal_down_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_en && dn_up && illegal_now) |=> (count == TOP_V));

  assert_end_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    at_end |-> (count == TOP_V || count == '0));

  assert_ripple_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ripple_n && !load) |=> (count == '0 || count == TOP_V));

endmodule

// File: tb/sim_bcd_updown_ctr.sv
module sim_bcd_updown_ctr;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dn_up = 1'b0;
  logic       cnt_en = 1'b0;
  logic       load = 1'b0;
  logic [3:0] load_val = 4'd0;
  logic [3:0] count;
  logic       at_end;
  logic       ripple_n;

  int checks = 0;
  int errors = 0;
  int ref_cnt = 0;
  string cnt_tag = "R1";

  always #5 clk = ~clk;

  bcd_updown_ctr u0 (
    .clk(clk), .rst_n(rst_n), .dn_up(dn_up), .cnt_en(cnt_en),
    .load(load), .load_val(load_val),
    .count(count), .at_end(at_end), .ripple_n(ripple_n)
  );

  // behavioural reference, updated on the same edge as the design
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_cnt = 0; cnt_tag = "R1";
    end else if (load) begin
      ref_cnt = int'(load_val); cnt_tag = "R5";
    end else if (!cnt_en) begin
      cnt_tag = "R4";
    end else if (!dn_up) begin
      if (ref_cnt > 9) begin ref_cnt = 0; cnt_tag = "R6"; end
      else begin ref_cnt = (ref_cnt + 1) % 10; cnt_tag = "R2"; end
    end else begin
      if (ref_cnt > 9) begin ref_cnt = 9; cnt_tag = "R7"; end
      else begin ref_cnt = (ref_cnt + 9) % 10; cnt_tag = "R3"; end
    end
  end

  task automatic compare();
    int  exp_end;
    int  exp_rip;
    exp_end = ((!dn_up && ref_cnt == 9) || (dn_up && ref_cnt == 0)) ? 1 : 0;
    exp_rip = (cnt_en && exp_end == 1) ? 0 : 1;
    checks++;
    if (int'(count) != ref_cnt) begin
      errors++;
      $display("FAIL %s count: actual %0d expected %0d", cnt_tag, count, ref_cnt);
    end
    checks++;
    if (int'(at_end) != exp_end) begin
      errors++;
      $display("FAIL R8 at_end: actual %0d expected %0d (count %0d dir %0d)",
               at_end, exp_end, ref_cnt, dn_up);
    end
    checks++;
    if (int'(ripple_n) != exp_rip) begin
      errors++;
      $display("FAIL R9 ripple_n: actual %0d expected %0d", ripple_n, exp_rip);
    end
  endtask

  // check the outcome of the previous edge, then set up the next one
  task automatic step(input logic ld, input logic en, input logic dn, input logic [3:0] v);
    @(negedge clk);
    compare();
    load = ld; cnt_en = en; dn_up = dn; load_val = v;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    // R1: reset state, with enable active during reset
    cnt_en = 1'b1;
    repeat (3) begin
      @(negedge clk);
      compare();
    end
    @(negedge clk);
    rst_n = 1'b1;
    cnt_en = 1'b0;

    // R2: upward run through two wraps
    for (int i = 0; i < 24; i++) step(1'b0, 1'b1, 1'b0, 4'd0);
    // R3: downward run through two wraps
    for (int i = 0; i < 24; i++) step(1'b0, 1'b1, 1'b1, 4'd0);
    // R4: hold in both directions
    for (int i = 0; i < 6; i++) step(1'b0, 1'b0, i[0], 4'd0);

    // R5 with R6/R7: load every value, then step up and down from it
    for (int v = 0; v < 16; v++) begin
      step(1'b1, v[1], v[0], 4'(v));
      step(1'b0, 1'b1, 1'b0, 4'd0);
      step(1'b1, 1'b0, 1'b1, 4'(v));
      step(1'b0, 1'b1, 1'b1, 4'd0);
      step(1'b1, 1'b1, 1'b0, 4'(v));
      step(1'b0, 1'b0, v[2], 4'd0);
    end

    // direction reversal at the terminal values (R8, R9)
    step(1'b1, 1'b0, 1'b0, 4'd9);
    step(1'b0, 1'b1, 1'b1, 4'd0);
    step(1'b0, 1'b1, 1'b0, 4'd0);
    step(1'b1, 1'b0, 1'b1, 4'd0);
    step(1'b0, 1'b1, 1'b0, 4'd0);
    step(1'b0, 1'b1, 1'b1, 4'd0);

    // mixed stimulus
    for (int i = 0; i < 400; i++) begin
      logic [3:0] r;
      r = 4'($urandom_range(0, 15));
      step(($urandom_range(0, 7) == 0), ($urandom_range(0, 3) != 0),
           1'($urandom_range(0, 1)), r);
    end
    step(1'b0, 1'b0, 1'b0, 4'd0);
    @(negedge clk);
    compare();
    summary();
  end

endmodule